// File: doc/BRIEF.md
# Configuration Readiness Lock

This block keeps the boot-time control word that a local processor fills in before a host discovers the device. The word says how many host-visible functions exist and carries a ready flag. Until boot code sets the ready flag, every host access is answered with a retry. Setting the flag makes it permanent until reset. From then on the control word cannot change, and local writes into configuration space are refused.

The local side writes the control word through a simple strobe-and-data port and reads it back at any time. Local writes aimed at configuration space pass through this block as a write request. The block forwards the request as a qualified strobe only while the device is not yet locked. A refused local write of either kind sets a sticky error flag. The host side raises a request and receives either an accept or a retry one cycle later. The function count and a contiguous enable mask drive the configuration header logic.

Top module: `cfg_ready_lock`

## Requirements
- R1: After reset the control word reads 0: one function, ready flag 0. `fn_count` is 1, `fn_enable` is 3'b001, and `cfg_locked`, `loc_wr_refused`, `host_ack` and `host_retry` are all 0.
- R2: While unlocked, a local control write stores data bits 1:0 as the function selector and bit 2 as the ready flag. The new value is visible on `loc_ctrl_rdata` the cycle after the write. Bits above bit 2 always read as 0, whatever was written.
- R3: `fn_count` decodes the selector as follows: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 3.
- R4: `fn_enable` bit i is 1 exactly when i is less than `fn_count`, so the enabled functions always start at function 0 with no gaps.
- R5: A host request sampled while the ready flag is 0 gives `host_retry`=1 and `host_ack`=0 in the following cycle.
- R6: A host request sampled while the ready flag is 1 gives `host_ack`=1 and `host_retry`=0 in the following cycle. A cycle without a request gives neither response in the next cycle.
- R7: Once the ready flag is 1, a local control write has no effect: the readback value and both outputs derived from it stay unchanged.
- R8: `cfg_we_ok` follows `loc_cfg_we` in the same cycle while unlocked, and is held at 0 while locked.
- R9: A local control write or configuration write made while locked sets `loc_wr_refused` from the next cycle on. The flag stays set until reset. Writes made while unlocked never set it.
- R10: `cfg_locked` equals the stored ready flag, which is readback bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_ctrl_we | input | 1 | Local write strobe for the control word |
| loc_ctrl_wdata | input | REG_W | Local write data for the control word |
| loc_ctrl_rdata | output | REG_W | Control word readback |
| loc_cfg_we | input | 1 | Local request to write configuration space |
| cfg_we_ok | output | 1 | Qualified configuration-space write strobe |
| loc_wr_refused | output | 1 | Sticky flag: a local write was refused |
| host_req | input | 1 | Host access request, one cycle per access |
| host_ack | output | 1 | Host access accepted (one cycle after request) |
| host_retry | output | 1 | Host access terminated with retry (one cycle after request) |
| fn_count | output | 2 | Number of enabled functions (1 to 3) |
| fn_enable | output | 3 | Enable mask per function, contiguous from function 0 |
| cfg_locked | output | 1 | Ready flag set; configuration frozen |

## Verification
Three kinds of result arrive on different schedules. The stored control word is a register, so readback, the function count, the enable mask, the lock state and the error flag change one edge after the write. The host response is also registered and appears one cycle after the request is sampled. The qualified configuration strobe is combinational and is valid in the same cycle as the request. The bench drives inputs just after a rising edge. It checks the registered results just after the following edge, and checks the same-cycle strobe before that edge, so each sample falls in the cycle the result is due.

// File: rtl/cfg_ready_lock.sv
module cfg_ready_lock #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_ctrl_we,
  input  logic [REG_W-1:0] loc_ctrl_wdata,
  output logic [REG_W-1:0] loc_ctrl_rdata,
  input  logic             loc_cfg_we,
  output logic             cfg_we_ok,
  output logic             loc_wr_refused,
  input  logic             host_req,
  output logic             host_ack,
  output logic             host_retry,
  output logic [1:0]       fn_count,
  output logic [2:0]       fn_enable,
  output logic             cfg_locked
);
  localparam int NUM_FN = 3;
  localparam int RSV_W  = REG_W - 3;

  logic [1:0] sel_q;
  logic       ready_q;
  logic       err_q;
  logic       ack_q, retry_q;
  logic       refuse;

  assign refuse = ready_q & (loc_ctrl_we | loc_cfg_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 2'b00;
      ready_q <= 1'b0;
    end else if (loc_ctrl_we && !ready_q) begin
      sel_q   <= loc_ctrl_wdata[1:0];
      ready_q <= loc_ctrl_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      ack_q   <= host_req & ready_q;
      retry_q <= host_req & ~ready_q;
    end
  end

  assign fn_count = (sel_q[1]) ? 2'd3 : {1'b0, sel_q[0]} + 2'd1;

  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn_en
    assign fn_enable[i] = (2'(i) < fn_count);
  end

  assign loc_ctrl_rdata = {{RSV_W{1'b0}}, ready_q, sel_q};
  assign cfg_we_ok      = loc_cfg_we & ~ready_q;
  assign loc_wr_refused = err_q;
  assign host_ack       = ack_q;
  assign host_retry     = retry_q;
  assign cfg_locked     = ready_q;
endmodule

// File: rtl/cfg_ready_lock_chk.sv
module cfg_ready_lock_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loc_ctrl_we,
  input logic [REG_W-1:0] loc_ctrl_rdata,
  input logic             loc_cfg_we,
  input logic             cfg_we_ok,
  input logic             loc_wr_refused,
  input logic             host_req,
  input logic             host_ack,
  input logic             host_retry,
  input logic [2:0]       fn_enable,
  input logic             cfg_locked
);
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> cfg_locked);
  p_frozen_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(loc_ctrl_rdata));
  p_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !cfg_locked) |=> (host_retry && !host_ack));
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && cfg_locked) |=> (host_ack && !host_retry));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> (!host_ack && !host_retry));
  p_cfg_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |-> !cfg_we_ok);
  p_cfg_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_locked && loc_cfg_we) |-> cfg_we_ok);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_refused |=> loc_wr_refused);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && (loc_ctrl_we || loc_cfg_we)) |=> loc_wr_refused);
  p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fn_enable[0] && (!fn_enable[2] || fn_enable[1]));
  p_lock_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ctrl_rdata[2] == cfg_locked);
endmodule

bind cfg_ready_lock cfg_ready_lock_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_ctrl_we(loc_ctrl_we),
  .loc_ctrl_rdata(loc_ctrl_rdata), .loc_cfg_we(loc_cfg_we),
  .cfg_we_ok(cfg_we_ok), .loc_wr_refused(loc_wr_refused),
  .host_req(host_req), .host_ack(host_ack), .host_retry(host_retry),
  .fn_enable(fn_enable), .cfg_locked(cfg_locked)
);

// File: tb/tb_cfg_ready_lock.sv
module tb_cfg_ready_lock;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             loc_ctrl_we;
  logic [REG_W-1:0] loc_ctrl_wdata;
  logic [REG_W-1:0] loc_ctrl_rdata;
  logic             loc_cfg_we;
  logic             cfg_we_ok;
  logic             loc_wr_refused;
  logic             host_req;
  logic             host_ack;
  logic             host_retry;
  logic [1:0]       fn_count;
  logic [2:0]       fn_enable;
  logic             cfg_locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_ready_lock #(.REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .loc_ctrl_we(loc_ctrl_we), .loc_ctrl_wdata(loc_ctrl_wdata),
    .loc_ctrl_rdata(loc_ctrl_rdata), .loc_cfg_we(loc_cfg_we),
    .cfg_we_ok(cfg_we_ok), .loc_wr_refused(loc_wr_refused),
    .host_req(host_req), .host_ack(host_ack), .host_retry(host_retry),
    .fn_count(fn_count), .fn_enable(fn_enable), .cfg_locked(cfg_locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    loc_ctrl_we = 1'b0; loc_ctrl_wdata = '0; loc_cfg_we = 1'b0; host_req = 1'b0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 rdata", 32'(loc_ctrl_rdata), 0);
    chk("R1 count", 32'(fn_count), 1);
    chk("R1 enable", 32'(fn_enable), 3'b001);
    chk("R1 locked", 32'(cfg_locked), 0);
    chk("R1 refused", 32'(loc_wr_refused), 0);
    chk("R1 host resp", 32'({host_ack, host_retry}), 0);
  endtask

  task automatic ctrl_write(input logic [REG_W-1:0] d);
    loc_ctrl_we = 1'b1; loc_ctrl_wdata = d;
    step();
    loc_ctrl_we = 1'b0; loc_ctrl_wdata = '0;
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      int n;
      n = (s >= 2) ? 3 : s + 1;
      ctrl_write(REG_W'(16'hFFF8 | s));
      chk("R2 readback reserved zero", 32'(loc_ctrl_rdata), 32'(s));
      chk("R3 count decode", 32'(fn_count), 32'(n));
      chk("R4 contiguous enable", 32'(fn_enable), 32'((1 << n) - 1));
      chk("R10 locked low", 32'(cfg_locked), 0);
    end
  endtask

  task automatic t_unlocked_access();
    host_req = 1'b1;
    step();
    host_req = 1'b0;
    chk("R5 retry", 32'(host_retry), 1);
    chk("R5 no ack", 32'(host_ack), 0);
    loc_cfg_we = 1'b1;
    #1;
    chk("R8 pass-through", 32'(cfg_we_ok), 1);
    step();
    loc_cfg_we = 1'b0;
    chk("R6 idle response", 32'({host_ack, host_retry}), 0);
    chk("R9 no error when unlocked", 32'(loc_wr_refused), 0);
  endtask

  task automatic t_lock();
    ctrl_write(REG_W'(16'h0005));
    chk("R2 lock write readback", 32'(loc_ctrl_rdata), 5);
    chk("R10 locked", 32'(cfg_locked), 1);
    chk("R3 count two", 32'(fn_count), 2);
    host_req = 1'b1;
    step();
    host_req = 1'b0;
    chk("R6 ack", 32'(host_ack), 1);
    chk("R6 no retry", 32'(host_retry), 0);
  endtask

  task automatic t_locked_ctrl_write();
    ctrl_write(REG_W'(16'h0002));
    chk("R7 readback frozen", 32'(loc_ctrl_rdata), 5);
    chk("R7 still locked", 32'(cfg_locked), 1);
    chk("R7 count unchanged", 32'(fn_count), 2);
    chk("R9 refused set", 32'(loc_wr_refused), 1);
    repeat (3) step();
    chk("R9 refused sticky", 32'(loc_wr_refused), 1);
  endtask

  task automatic t_locked_cfg_write();
    t_reset();
    ctrl_write(REG_W'(16'h0006));
    chk("R10 locked after reset+write", 32'(cfg_locked), 1);
    chk("R9 clear before refusal", 32'(loc_wr_refused), 0);
    loc_cfg_we = 1'b1;
    #1;
    chk("R8 blocked", 32'(cfg_we_ok), 0);
    step();
    loc_cfg_we = 1'b0;
    chk("R9 cfg refusal", 32'(loc_wr_refused), 1);
    chk("R7 value kept", 32'(loc_ctrl_rdata), 6);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_unlocked_access();
    t_lock();
    t_locked_ctrl_write();
    t_locked_cfg_write();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule